// File: doc/BRIEF.md
# Load-Linked Address Check Unit

This unit carries out the load half of a load-linked / store-conditional pair in a small processor data path. The core presents a virtual address, the physical address that translation has already produced for it, an operand size (32-bit word or 64-bit doubleword) and a flag that says whether the core is in debug mode. The unit checks the virtual address against the natural alignment of the operand size.

A misaligned request does not reach memory. It raises a one-cycle address-error-on-load exception. When the core is not in debug mode, the faulting virtual address is also captured in a bad-address register.

An aligned request issues a single read over a valid/ready handshake and then waits for the returned data. When the data arrives, three link registers are loaded in the same clock edge: the physical address, the virtual address and the loaded value. The loaded value is also returned as the result. A word result is sign-extended to 64 bits and a doubleword result is passed through unchanged. A separate store-conditional unit reads the link registers.

Top module: `ll_link_unit`

## Requirements
- R1: A word request (`req_dword`=0) is misaligned when `req_vaddr[1:0]` is nonzero, and it then raises the exception.
- R2: A doubleword request (`req_dword`=1) is misaligned when `req_vaddr[2:0]` is nonzero. A doubleword at an address that is only word-aligned faults, and a word at the same address does not.
- R3: An exception raises `exc_valid` for exactly one cycle, in the cycle after the request is accepted, with `exc_code` = 4. In that cycle `res_valid` is low and `req_ready` is low.
- R4: A misaligned request issues no memory read and leaves `link_paddr`, `link_vaddr` and `link_value` unchanged.
- R5: On a misaligned request with `debug_mode`=0, `bad_vaddr` takes the faulting virtual address.
- R6: On a misaligned request with `debug_mode`=1, `bad_vaddr` keeps its previous value.
- R7: An aligned request raises `mem_rd_valid` in the next cycle, with `mem_rd_addr` equal to the request's physical address and `mem_rd_dword` equal to its size. Both are held stable until `mem_rd_ready` is seen high.
- R8: On the clock edge where `mem_rsp_valid` is seen while waiting, `link_paddr`, `link_vaddr` and `link_value` are loaded and `res_valid` rises for one cycle with `res_data` equal to `link_value`.
- R9: A word result is `mem_rsp_data[31:0]` sign-extended to 64 bits.
- R10: A doubleword result is `mem_rsp_data` unchanged.
- R11: A synchronous reset clears the link registers, `bad_vaddr`, `exc_valid`, `res_valid` and `mem_rd_valid`, and leaves `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load-linked request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | VA_W | Virtual address of the request |
| req_paddr | input | PA_W | Translated physical address |
| req_dword | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| debug_mode | input | 1 | Core is in debug mode |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | PA_W | Physical read address |
| mem_rd_dword | output | 1 | Read size, 1 = 64-bit |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned read data |
| res_valid | output | 1 | Result pulse |
| res_data | output | 64 | Extended result |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 5 | Exception code, 4 = address error on load |
| bad_vaddr | output | VA_W | Bad-address register |
| link_paddr | output | PA_W | Linked physical address |
| link_vaddr | output | VA_W | Linked virtual address |
| link_value | output | 64 | Linked loaded value |

## Verification
The bench targets the address that is word-aligned but not doubleword-aligned. A design that used one alignment mask for both sizes would either let the doubleword through to memory or fault on the word. It sends a word whose bit 31 is set, so that a design that zero-extends, or that sign-extends doubleword data, returns a wrong upper half. It makes a fault in debug mode after a normal fault, and a design that ignores the flag would overwrite the bad address. It stalls both the read handshake and the response, and checks after each fault that the link registers still hold the values from the previous load, which catches a design that updates them too early or on the wrong path.

// File: rtl/ll_pkg.sv
package ll_pkg;
  localparam int XLEN = 64;
  localparam logic [4:0] EXC_ADDR_LOAD = 5'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ll_state_e;

  // Alignment test on the three low address bits for the chosen operand size.
  function automatic logic is_misaligned(input logic [2:0] low_bits, input logic dword);
    if (dword) return (low_bits != 3'b000);
    return (low_bits[1:0] != 2'b00);
  endfunction

  // Word results are sign-extended; doubleword results pass through.
  function automatic logic [XLEN-1:0] extend_result(input logic [XLEN-1:0] raw, input logic dword);
    if (dword) return raw;
    return {{(XLEN-32){raw[31]}}, raw[31:0]};
  endfunction
endpackage

// File: rtl/ll_align_check.sv
module ll_align_check (
  input  logic [2:0] low_bits,
  input  logic       dword,
  output logic       misaligned
);
  import ll_pkg::*;
  assign misaligned = is_misaligned(low_bits, dword);
endmodule

// File: rtl/ll_ctrl.sv
module ll_ctrl #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] req_paddr,
  input  logic            req_dword,
  input  logic            misaligned,
  input  logic            mem_rd_ready,
  input  logic            mem_rsp_valid,
  output logic            req_ready,
  output logic            mem_rd_valid,
  output logic [PA_W-1:0] mem_rd_addr,
  output logic            mem_rd_dword,
  output logic            fault_evt,
  output logic            rsp_evt,
  output logic            exc_valid,
  output logic [4:0]      exc_code,
  output logic [VA_W-1:0] held_vaddr
);
  import ll_pkg::*;

  ll_state_e state;
  logic      accept_evt;
  logic      start_evt;

  assign req_ready    = (state == ST_IDLE) && !exc_valid;
  assign accept_evt   = req_valid && req_ready;
  assign fault_evt    = accept_evt && misaligned;
  assign start_evt    = accept_evt && !misaligned;
  assign rsp_evt      = (state == ST_WAIT) && mem_rsp_valid;
  assign mem_rd_valid = (state == ST_ISSUE);
  assign exc_code     = EXC_ADDR_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      exc_valid    <= 1'b0;
      mem_rd_addr  <= '0;
      mem_rd_dword <= 1'b0;
      held_vaddr   <= '0;
    end else begin
      exc_valid <= fault_evt;
      case (state)
        ST_IDLE: if (start_evt) begin
          state        <= ST_ISSUE;
          mem_rd_addr  <= req_paddr;
          mem_rd_dword <= req_dword;
          held_vaddr   <= req_vaddr;
        end
        ST_ISSUE: if (mem_rd_ready) state <= ST_WAIT;
        ST_WAIT:  if (mem_rsp_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R3: the exception is a single-cycle pulse and is never paired with a result
  assert_exc_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid);
  // R1 R2: a fault accepted in a cycle raises the exception in the next
  assert_fault_raises_R1: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> exc_valid);
  // R4: a faulting request never starts a memory read
  assert_fault_no_read_R4: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> !mem_rd_valid);
  // R7: a pending read holds its address and size until accepted
  assert_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr) && $stable(mem_rd_dword)));
endmodule

// File: rtl/ll_link_regs.sv
module ll_link_regs #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fault_evt,
  input  logic                    debug_mode,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic                    rsp_evt,
  input  logic [VA_W-1:0]         held_vaddr,
  input  logic [PA_W-1:0]         held_paddr,
  input  logic                    held_dword,
  input  logic [ll_pkg::XLEN-1:0] rsp_data,
  output logic [VA_W-1:0]         bad_vaddr,
  output logic [PA_W-1:0]         link_paddr,
  output logic [VA_W-1:0]         link_vaddr,
  output logic [ll_pkg::XLEN-1:0] link_value,
  output logic                    res_valid,
  output logic                    res_dword
);
  import ll_pkg::*;

  logic            bad_capture;
  logic [XLEN-1:0] ext_value;

  assign bad_capture = fault_evt && !debug_mode;
  assign ext_value   = extend_result(rsp_data, held_dword);

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_vaddr  <= '0;
      link_paddr <= '0;
      link_vaddr <= '0;
      link_value <= '0;
      res_valid  <= 1'b0;
      res_dword  <= 1'b0;
    end else begin
      res_valid <= rsp_evt;
      if (bad_capture) bad_vaddr <= req_vaddr;
      if (rsp_evt) begin
        link_paddr <= held_paddr;
        link_vaddr <= held_vaddr;
        link_value <= ext_value;
        res_dword  <= held_dword;
      end
    end
  end

  // R6: debug mode suppresses the bad-address update
  assert_debug_keeps_bad_R6: assert property (@(posedge clk) disable iff (rst)
    (fault_evt && debug_mode) |=> $stable(bad_vaddr));
  // R4 R8: link state changes only after a returned response
  assert_link_only_on_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_evt |=> ($stable(link_paddr) && $stable(link_vaddr) && $stable(link_value)));
  // R9: a word result has a sign-filled upper half
  assert_word_sign_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_dword) |-> (link_value[XLEN-1:32] == {(XLEN-32){link_value[31]}}));
endmodule

// File: rtl/ll_link_unit.sv
module ll_link_unit #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [PA_W-1:0]         req_paddr,
  input  logic                    req_dword,
  input  logic                    debug_mode,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [PA_W-1:0]         mem_rd_addr,
  output logic                    mem_rd_dword,
  input  logic                    mem_rsp_valid,
  input  logic [ll_pkg::XLEN-1:0] mem_rsp_data,
  output logic                    res_valid,
  output logic [ll_pkg::XLEN-1:0] res_data,
  output logic                    exc_valid,
  output logic [4:0]              exc_code,
  output logic [VA_W-1:0]         bad_vaddr,
  output logic [PA_W-1:0]         link_paddr,
  output logic [VA_W-1:0]         link_vaddr,
  output logic [ll_pkg::XLEN-1:0] link_value
);
  logic            misaligned;
  logic            fault_evt;
  logic            rsp_evt;
  logic            res_dword;
  logic [VA_W-1:0] held_vaddr;

  ll_align_check u_align (
    .low_bits   (req_vaddr[2:0]),
    .dword      (req_dword),
    .misaligned (misaligned)
  );

  ll_ctrl #(.VA_W(VA_W), .PA_W(PA_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_paddr     (req_paddr),
    .req_dword     (req_dword),
    .misaligned    (misaligned),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_dword  (mem_rd_dword),
    .fault_evt     (fault_evt),
    .rsp_evt       (rsp_evt),
    .exc_valid     (exc_valid),
    .exc_code      (exc_code),
    .held_vaddr    (held_vaddr)
  );

  ll_link_regs #(.VA_W(VA_W), .PA_W(PA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .fault_evt  (fault_evt),
    .debug_mode (debug_mode),
    .req_vaddr  (req_vaddr),
    .rsp_evt    (rsp_evt),
    .held_vaddr (held_vaddr),
    .held_paddr (mem_rd_addr),
    .held_dword (mem_rd_dword),
    .rsp_data   (mem_rsp_data),
    .bad_vaddr  (bad_vaddr),
    .link_paddr (link_paddr),
    .link_vaddr (link_vaddr),
    .link_value (link_value),
    .res_valid  (res_valid),
    .res_dword  (res_dword)
  );

  assign res_data = link_value;

  // R3: no result is presented while the exception is raised
  assert_exc_excludes_res_R3: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !res_valid);
  // R5: a fault outside debug mode captures the faulting address
  assert_bad_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && misaligned && !debug_mode) |=> (bad_vaddr == $past(req_vaddr)));
endmodule

// File: tb/test_ll_link_unit.sv
module test_ll_link_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 32;
  localparam int PA_W = 36;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid, req_ready, req_dword, debug_mode;
  logic [VA_W-1:0] req_vaddr;
  logic [PA_W-1:0] req_paddr;
  logic            mem_rd_valid, mem_rd_ready, mem_rd_dword, mem_rsp_valid;
  logic [PA_W-1:0] mem_rd_addr;
  logic [63:0]     mem_rsp_data, res_data, link_value;
  logic            res_valid, exc_valid;
  logic [4:0]      exc_code;
  logic [VA_W-1:0] bad_vaddr, link_vaddr;
  logic [PA_W-1:0] link_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ll_link_unit #(.VA_W(VA_W), .PA_W(PA_W)) i_ll_link_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_paddr(req_paddr), .req_dword(req_dword),
    .debug_mode(debug_mode), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_dword(mem_rd_dword), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_data(res_data),
    .exc_valid(exc_valid), .exc_code(exc_code), .bad_vaddr(bad_vaddr),
    .link_paddr(link_paddr), .link_vaddr(link_vaddr), .link_value(link_value)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_ext(input logic [63:0] d, input logic dw);
    logic [63:0] r;
    r = dw ? d : {{32{d[31]}}, d[31:0]};
    return r;
  endfunction

  task automatic test_reset();
    rst = 1'b1; req_valid = 0; req_vaddr = '0; req_paddr = '0; req_dword = 0;
    debug_mode = 0; mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 link_paddr", 64'(link_paddr), 64'd0);
    chk("R11 link_vaddr", 64'(link_vaddr), 64'd0);
    chk("R11 link_value", link_value, 64'd0);
    chk("R11 bad_vaddr", 64'(bad_vaddr), 64'd0);
    chk("R11 exc/res/rd idle", {61'd0, exc_valid, res_valid, mem_rd_valid}, 64'd0);
    chk("R11 req_ready", 64'(req_ready), 64'd1);
  endtask

  task automatic test_load(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                           input logic dw, input logic [63:0] data, input string tag);
    logic [63:0] exp = model_ext(data, dw);
    req_valid = 1; req_vaddr = va; req_paddr = pa; req_dword = dw;
    @(negedge clk);
    req_valid = 0;
    chk({"R7 rd_valid ", tag}, 64'(mem_rd_valid), 64'd1);
    chk({"R7 rd_addr ", tag}, 64'(mem_rd_addr), 64'(pa));
    chk({"R7 rd_dword ", tag}, 64'(mem_rd_dword), 64'(dw));
    chk({"R1 R2 no exc ", tag}, 64'(exc_valid), 64'd0);
    @(negedge clk);
    chk({"R7 held valid ", tag}, 64'(mem_rd_valid), 64'd1);
    chk({"R7 held addr ", tag}, 64'(mem_rd_addr), 64'(pa));
    mem_rd_ready = 1;
    @(negedge clk);
    mem_rd_ready = 0;
    chk({"R7 rd dropped ", tag}, 64'(mem_rd_valid), 64'd0);
    @(negedge clk);
    chk({"R8 no early res ", tag}, 64'(res_valid), 64'd0);
    mem_rsp_valid = 1; mem_rsp_data = data;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = '0;
    chk({"R8 res_valid ", tag}, 64'(res_valid), 64'd1);
    chk({dw ? "R10 res_data " : "R9 res_data ", tag}, res_data, exp);
    chk({"R8 link_value ", tag}, link_value, exp);
    chk({"R8 link_paddr ", tag}, 64'(link_paddr), 64'(pa));
    chk({"R8 link_vaddr ", tag}, 64'(link_vaddr), 64'(va));
    @(negedge clk);
    chk({"R8 res pulse ", tag}, 64'(res_valid), 64'd0);
  endtask

  task automatic test_fault(input logic [VA_W-1:0] va, input logic dw,
                            input logic dbg, input string tag);
    logic [VA_W-1:0] old_bad = bad_vaddr;
    logic [VA_W-1:0] old_lv  = link_vaddr;
    logic [PA_W-1:0] old_lp  = link_paddr;
    logic [63:0]     old_val = link_value;
    req_valid = 1; req_vaddr = va; req_paddr = 36'h0_dead_0000; req_dword = dw; debug_mode = dbg;
    @(negedge clk);
    req_valid = 0; debug_mode = 0;
    chk({"R1 R2 exc_valid ", tag}, 64'(exc_valid), 64'd1);
    chk({"R3 exc_code ", tag}, 64'(exc_code), 64'd4);
    chk({"R3 res low ", tag}, 64'(res_valid), 64'd0);
    chk({"R3 ready low ", tag}, 64'(req_ready), 64'd0);
    chk({"R4 no read ", tag}, 64'(mem_rd_valid), 64'd0);
    chk({"R4 link_vaddr ", tag}, 64'(link_vaddr), 64'(old_lv));
    chk({"R4 link_paddr ", tag}, 64'(link_paddr), 64'(old_lp));
    chk({"R4 link_value ", tag}, link_value, old_val);
    if (dbg) chk({"R6 bad kept ", tag}, 64'(bad_vaddr), 64'(old_bad));
    else     chk({"R5 bad captured ", tag}, 64'(bad_vaddr), 64'(va));
    @(negedge clk);
    chk({"R3 exc pulse ", tag}, 64'(exc_valid), 64'd0);
    chk({"R4 still no read ", tag}, 64'(mem_rd_valid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_load(32'h0000_1000, 36'h1_2345_1000, 1'b0, 64'hffff_ffff_1234_5678, "word positive R9");
    test_load(32'h0000_1004, 36'h1_2345_1004, 1'b0, 64'h0000_0000_8765_4321, "word negative R9");
    test_load(32'h0000_2008, 36'h2_0000_2008, 1'b1, 64'h8123_4567_89ab_cdef, "dword R10");
    test_fault(32'h0000_3002, 1'b0, 1'b0, "word bit1 R1");
    test_fault(32'h0000_3001, 1'b0, 1'b0, "word bit0 R1");
    test_fault(32'h0000_3004, 1'b1, 1'b0, "dword at word boundary R2");
    test_load(32'h0000_3004, 36'h3_0000_3004, 1'b0, 64'h0000_0000_7fff_ffff, "word at same addr R2");
    test_fault(32'h0000_4003, 1'b0, 1'b1, "debug word R6");
    test_fault(32'h0000_4006, 1'b1, 1'b1, "debug dword R6");
    test_fault(32'h0000_5007, 1'b1, 1'b0, "dword low bits R2");
    test_load(32'h0000_6010, 36'h6_0000_6010, 1'b1, 64'h0000_0000_ffff_ffff, "dword no extend R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule